// File: doc/BRIEF.md
# Single-Cycle Scalar Integer Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It holds a program in an internal word-organised instruction store, a 32-entry register file, an arithmetic/logic unit, a next-address unit and an internal word-organised data store. It executes a small load/store instruction set: register arithmetic and logic, shifts by a constant amount, add-immediate, word load and store, equality and inequality branches relative to the program counter, and absolute jumps within the current 256 MB region.

A program is written into the instruction store through a load port, normally while reset is held. Execution then starts at address 0 once reset is released. Two read-only peek ports expose any general register and any data word. A test environment can therefore check results without stopping the core.

Top module: `scalar_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 and every general register and every data word becomes 0.
- R2: An instruction that is neither a taken branch nor a jump advances the program counter by 4. The instruction store is indexed by bits [IMEM_AW+1:2] of the program counter.
- R3: Opcode 0 carries register operations in the fields op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. Funct 32 writes rs+rt to rd, 34 writes rs-rt, 36 writes rs AND rt, 37 writes rs OR rt, and 39 writes NOT(rs OR rt).
- R4: Funct 0 writes rt shifted left by shamt to rd. Funct 2 writes rt shifted right logically by shamt to rd.
- R5: Opcode 8 writes rs plus the sign-extended imm[15:0] to rt.
- R6: Opcode 35 loads rt from the data word at rs+sext(imm). Opcode 43 stores rt to that word. The data word index is bits [DMEM_AW+1:2] of that address. No other instruction writes the data store.
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. The target is PC+4 plus sext(imm) shifted left by 2. When the branch is not taken, execution falls through to PC+4.
- R8: Opcode 2 jumps to {(PC+4)[31:28], addr[25:0], 2'b00}.
- R9: Register 0 always reads as 0, and writes to it have no effect.
- R10: Any other opcode, and any other funct under opcode 0, writes neither a register nor the data store, and the program counter advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_we | input | 1 | Write strobe for the instruction store |
| load_addr | input | IMEM_AW | Instruction store word index to write |
| load_word | input | 32 | Instruction word to write |
| pc | output | 32 | Current program counter |
| reg_sel | input | 5 | General register to peek |
| reg_val | output | 32 | Value of the selected register |
| mem_sel | input | DMEM_AW | Data word index to peek |
| mem_val | output | 32 | Value of the selected data word |

## Verification
The test program places a not-taken beq directly before a taken bne. A core that inverts or confuses either condition lands on a marker write to r12. A backward bne loop counts to a register value and catches a wrong sign in the offset extension. A jump skips a marker write to r13, and a final self-jump pins the resting PC at 96; an incorrect jump target would change that value. The program also writes to r0, executes an unknown opcode and an unknown funct, and issues a store with a negative offset. A core that writes r0, decodes garbage as an operation or zero-extends the offset would leave wrong values in the registers or in the data store. A reset in the middle of the run must clear the data store and the registers, and three further cycles must leave exactly three instructions retired.

// File: rtl/scalar_core_pkg.sv
// Shared encodings and control types for the single-cycle scalar core.
// Assumes 32-bit instructions and a 32-entry register file.
package scalar_core_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_JMP  = 6'd2;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;

    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_NOR = 6'd39;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL
    } alu_op_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    reg_we;
        logic    dst_rd;
        logic    use_imm;
        logic    mem_rd;
        logic    mem_we;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
        logic    illegal;
    } ctrl_t;
endpackage

// File: rtl/core_decode.sv
// Instruction decoder: maps opcode and funct to control signals.
// Assumes any unrecognised opcode or funct must behave as a no-op.
module core_decode
    import scalar_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Decode one instruction into its control bundle.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_REG: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_NOR:  ctrl.alu_op = ALU_NOR;
                    FN_SLL:  ctrl.alu_op = ALU_SLL;
                    FN_SRL:  ctrl.alu_op = ALU_SRL;
                    default: begin
                        ctrl.reg_we  = 1'b0;
                        ctrl.dst_rd  = 1'b0;
                        ctrl.illegal = 1'b1;
                    end
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.br_eq  = 1'b1;
            end
            OP_BNE: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.br_ne  = 1'b1;
            end
            OP_JMP:  ctrl.jump    = 1'b1;
            default: ctrl.illegal = 1'b1;
        endcase
    end

    // R10: an unknown encoding must never request a write.
    always_comb begin
        a_r10_illegal_quiet: assert (!(ctrl.illegal && (ctrl.reg_we || ctrl.mem_we)));
    end
endmodule

// File: rtl/core_alu.sv
// Combinational ALU for the scalar core. The shift amount comes from the
// instruction and is applied to operand b, which holds the rt value.
module core_alu
    import scalar_core_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [4:0]      shamt,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    // Select the result of the requested operation.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLL: y = b << shamt;
            ALU_SRL: y = b >> shamt;
            default: y = a + b;
        endcase
    end

    // Flag a zero result; branches use it as the equality test.
    always_comb zero = (y == '0);
endmodule

// File: rtl/core_regfile.sv
// General register file: two read ports for operands, one peek port and
// one write port. Entry 0 is never written, so it always reads as zero.
module core_regfile
    import scalar_core_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    input  logic [AW-1:0]   ra_peek,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    output logic [XLEN-1:0] rd_peek,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs_q [NREG];

    // Clear all entries on reset; otherwise write any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    // Read the ports asynchronously.
    always_comb begin
        rd_a    = regs_q[ra_a];
        rd_b    = regs_q[ra_b];
        rd_peek = regs_q[ra_peek];
    end

    // R9: entry zero keeps its zero value whatever the write port does.
    a_r9_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);
endmodule

// File: rtl/scalar_core.sv
// Single-cycle scalar core: fetch, decode, execute, memory access and
// write-back all complete in one clock. Instruction and data stores are
// internal word arrays. The program is written through the load port,
// normally while reset is held.
module scalar_core
    import scalar_core_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int IMEM_WORDS = 1 << IMEM_AW,
    localparam int DMEM_WORDS = 1 << DMEM_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_we,
    input  logic [IMEM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]    load_word,
    output logic [XLEN-1:0]    pc,
    input  logic [REG_AW-1:0]  reg_sel,
    output logic [XLEN-1:0]    reg_val,
    input  logic [DMEM_AW-1:0] mem_sel,
    output logic [XLEN-1:0]    mem_val
);
    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];
    logic [XLEN-1:0] pc_q, pc_next, pc_plus4;
    logic [XLEN-1:0] instr, imm_ext, br_off;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_data, ld_data;
    logic [REG_AW-1:0] wr_idx;
    logic            alu_zero, br_taken;
    ctrl_t           ctrl;

    // Write the instruction store from the load port.
    always_ff @(posedge clk) begin
        if (load_we) imem_q[load_addr] <= load_word;
    end

    // Fetch the word addressed by the program counter.
    always_comb instr = imem_q[pc_q[IMEM_AW+1:2]];

    core_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    core_regfile #(.NREG(32)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_a    (instr[25:21]),
        .ra_b    (instr[20:16]),
        .ra_peek (reg_sel),
        .rd_a    (rs_val),
        .rd_b    (rt_val),
        .rd_peek (reg_val),
        .we      (ctrl.reg_we),
        .wa      (wr_idx),
        .wd      (wb_data)
    );

    // Form the immediate operand and the destination register.
    always_comb begin
        imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
        br_off  = {imm_ext[XLEN-3:0], 2'b00};
        alu_b   = ctrl.use_imm ? imm_ext : rt_val;
        wr_idx  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    end

    core_alu u_alu (
        .op    (ctrl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (instr[10:6]),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    // Read the data word and choose the write-back source.
    always_comb begin
        ld_data = dmem_q[alu_y[DMEM_AW+1:2]];
        wb_data = ctrl.mem_rd ? ld_data : alu_y;
        mem_val = dmem_q[mem_sel];
    end

    // Clear the data store on reset; otherwise perform stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] <= '0;
        end else if (ctrl.mem_we) begin
            dmem_q[alu_y[DMEM_AW+1:2]] <= rt_val;
        end
    end

    // Choose among sequential, branch and jump successors.
    always_comb begin
        pc_plus4 = pc_q + 32'd4;
        br_taken = (ctrl.br_eq && alu_zero) || (ctrl.br_ne && !alu_zero);
        if (ctrl.jump)     pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
        else if (br_taken) pc_next = pc_plus4 + br_off;
        else               pc_next = pc_plus4;
    end

    // Hold the program counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc = pc_q;

    // R2 and R10: the program counter advances by 4 after any instruction
    // that does not redirect it.
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_taken && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // R7: a taken branch lands at the offset target.
    a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (pc_q == $past(pc_q) + 32'd4 + {$past(imm_ext[XLEN-3:0]), 2'b00}));

    // R8: a jump puts the 26-bit field into PC bits [27:2].
    a_r8_jump_field: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

    // R6: only the store opcode can write the data store.
    a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_we |-> (instr[31:26] == 6'd43));
endmodule

// File: tb/scalar_core_tb_top.sv
// Self-checking bench: loads a fixed program, runs it, then walks a table
// of expected register values. Directed checks cover reset and a restart.
module scalar_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IMEM_AW = 6;
    localparam int DMEM_AW = 6;
    localparam int PROG_LEN = 25;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input int sh, input int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                          input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int addr);
        return {op[5:0], addr[25:0]};
    endfunction

    localparam logic [31:0] PROG [PROG_LEN] = '{
        enc_i(8, 0, 1, 5),        // 0  r1 = 5               (R5)
        enc_i(8, 0, 2, -3),       // 1  r2 = -3              (R5)
        enc_r(1, 2, 3, 0, 32),    // 2  add                  (R3)
        enc_r(1, 2, 4, 0, 34),    // 3  sub
        enc_r(1, 2, 5, 0, 36),    // 4  and
        enc_r(1, 2, 6, 0, 37),    // 5  or
        enc_r(1, 2, 7, 0, 39),    // 6  nor
        enc_r(0, 1, 8, 4, 0),     // 7  shift left by 4      (R4)
        enc_r(0, 2, 9, 28, 2),    // 8  shift right by 28
        enc_i(8, 0, 0, 7),        // 9  write to r0          (R9)
        enc_i(43, 0, 4, 8),       // 10 store r4 at word 2   (R6)
        enc_i(35, 0, 10, 8),      // 11 load r10 from word 2
        enc_i(8, 0, 11, 12),      // 12 r11 = 12
        enc_i(43, 11, 9, -8),     // 13 store r9 at word 1
        enc_i(4, 1, 2, 1),        // 14 beq not taken        (R7)
        enc_i(5, 1, 2, 1),        // 15 bne taken, skips 16
        enc_i(8, 0, 12, 99),      // 16 marker, must not run
        enc_j(2, 19),             // 17 jump to 19           (R8)
        enc_i(8, 0, 13, 77),      // 18 marker, must not run
        enc_i(8, 14, 14, 1),      // 19 r14++
        enc_i(5, 14, 1, -2),      // 20 loop back until r14 == r1
        32'hFC00_0000,            // 21 unknown opcode       (R10)
        enc_r(1, 1, 15, 0, 1),    // 22 unknown funct
        enc_i(43, 0, 14, 12),     // 23 store r14 at word 3
        enc_j(2, 24)              // 24 self-jump
    };

    // Expected register file after the run: {index, value}, plus the requirement.
    localparam logic [36:0] EXP_REGS [16] = '{
        {5'd0,  32'h0000_0000}, {5'd1,  32'h0000_0005},
        {5'd2,  32'hFFFF_FFFD}, {5'd3,  32'h0000_0002},
        {5'd4,  32'h0000_0008}, {5'd5,  32'h0000_0005},
        {5'd6,  32'hFFFF_FFFD}, {5'd7,  32'h0000_0002},
        {5'd8,  32'h0000_0050}, {5'd9,  32'h0000_000F},
        {5'd10, 32'h0000_0008}, {5'd11, 32'h0000_000C},
        {5'd12, 32'h0000_0000}, {5'd13, 32'h0000_0000},
        {5'd14, 32'h0000_0005}, {5'd15, 32'h0000_0000}
    };
    localparam int EXP_REQ [16] = '{9, 5, 5, 3, 3, 3, 3, 3, 4, 4, 6, 5, 7, 8, 7, 10};

    logic               clk = 1'b0;
    logic               rst_n;
    logic               load_we;
    logic [IMEM_AW-1:0] load_addr;
    logic [31:0]        load_word;
    logic [31:0]        pc;
    logic [4:0]         reg_sel;
    logic [31:0]        reg_val;
    logic [DMEM_AW-1:0] mem_sel;
    logic [31:0]        mem_val;
    int                 n_checks = 0;
    int                 n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scalar_core #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_word (load_word),
        .pc        (pc),
        .reg_sel   (reg_sel),
        .reg_val   (reg_val),
        .mem_sel   (mem_sel),
        .mem_val   (mem_val)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek_reg(input int idx, input string tag, input logic [31:0] exp);
        reg_sel = idx[4:0];
        #1;
        check(tag, reg_val, exp);
    endtask

    task automatic peek_mem(input int idx, input string tag, input logic [31:0] exp);
        mem_sel = idx[DMEM_AW-1:0];
        #1;
        check(tag, mem_val, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_we = 1'b0; load_addr = '0; load_word = '0;
        reg_sel = '0; mem_sel = '0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < (1 << IMEM_AW); i++) begin
            load_we   = 1'b1;
            load_addr = i[IMEM_AW-1:0];
            load_word = (i < PROG_LEN) ? PROG[i] : 32'h0;
            @(negedge clk);
        end
        load_we = 1'b0;

        // R1: reset state
        check("R1 pc in reset", pc, 32'h0);
        peek_reg(1, "R1 r1 in reset", 32'h0);
        peek_mem(2, "R1 word 2 in reset", 32'h0);

        rst_n = 1'b1;
        repeat (100) @(negedge clk);

        // Table walk over the register file
        for (int i = 0; i < 16; i++) begin
            peek_reg(int'(EXP_REGS[i][36:32]),
                     $sformatf("R%0d reg %0d", EXP_REQ[i], EXP_REGS[i][36:32]),
                     EXP_REGS[i][31:0]);
        end
        peek_mem(0, "R10 word 0 untouched", 32'h0);
        peek_mem(1, "R6 negative offset store", 32'h0000_000F);
        peek_mem(2, "R6 store then load", 32'h0000_0008);
        peek_mem(3, "R7 loop count stored", 32'h0000_0005);
        check("R8 self-jump resting pc", pc, 32'd96);

        // R1: reset in the middle of execution
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pc after restart reset", pc, 32'h0);
        peek_reg(4, "R1 r4 cleared", 32'h0);
        peek_mem(2, "R1 word 2 cleared", 32'h0);

        // R2: three cycles retire exactly three instructions
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 pc after three steps", pc, 32'd12);
        peek_reg(3, "R2 third instruction retired", 32'h2);
        peek_reg(4, "R2 fourth instruction not yet", 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule